// File: doc/BRIEF.md
# Machine Timer with Time Capture

This block is a free-running machine timer. A 64-bit count advances by one on every clock and is reached through a simple single-cycle register port, as a set of 32-bit words. A compare register sits beside the count. While the count is at or above the compare value, the block holds a timer interrupt. Software can rewrite any word of the count or of the compare value at any time.

The block also timestamps external reference pulses, such as a pulse-per-second signal. The asynchronous capture input passes through a two-flop synchroniser. Each rising edge of the synchronised signal copies the current count into a capture register and raises a capture flag. If the flag is still set when the next edge arrives, an overrun flag records that a timestamp was missed. Software clears both flags by writing ones to them. A single interrupt output combines the enabled capture flag with the compare condition.

Top module: `mtc_timer_cap`

## Requirements
- R1: After reset the count is zero. On each clock with no count write it advances by one, and it wraps from all ones to zero.
- R2: The capture input is sampled by two flip-flops in series. The capture event is a rising edge at the second flop, and one edge gives exactly one event. The count captured is the value the count holds during the clock in which the second flop first reads high.
- R3: On a capture event the capture register takes the current count. A later event overwrites it with the newer timestamp, even when the flag is still set.
- R4: A capture event sets the capture flag, which is status word bit 0.
- R5: A capture event that arrives while the capture flag is set sets the overrun flag, which is status word bit 1. The flag value checked is the one held before that clock, whatever is written in the same cycle.
- R6: Writing the status word clears each flag whose data bit is 1 and leaves each flag whose bit is 0 unchanged. A capture event in the same cycle wins over a clear of the capture flag. An overrun set wins over an overrun clear.
- R7: The timer interrupt condition is true while the count, taken as unsigned 64 bits, is greater than or equal to the compare value. The compare value resets to all ones.
- R8: The `irq` output equals (capture flag AND capture enable) OR the timer condition. The capture enable is control word bit 0.
- R9: A write to one 32-bit half of the count or of the compare value takes effect at the next clock edge. The other half keeps its value, and in a count-write cycle the count does not advance.
- R10: Word addresses: 0 = count low, 1 = count high, 2 = compare low, 3 = compare high, 4 = capture low, 5 = capture high, 6 = status, 7 = control. Reads are combinational from `bus_addr`, and unused bits read as 0.
- R11: While reset is held, the count, capture, status and control words read 0, the compare value reads all ones, and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_in | input | 1 | Asynchronous capture pulse input |
| bus_wr | input | 1 | Write strobe for the word at bus_addr |
| bus_addr | input | ADDR_W (3) | Word address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for bus_addr |
| irq | output | 1 | Combined timer and capture interrupt |

## Verification
The bench builds the block with its default parameters: a 64-bit count split into two 32-bit words, and a two-stage synchroniser. Random writes to the upper count word move the count across most of the 64-bit range, so both outcomes of the unsigned compare are tested. A directed write of a value near all ones brings the wrap from all ones to zero into reach. Random toggling of the capture input together with random status writes produces events that coincide with clears, and events that arrive while a flag is still set.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
   // status word bit positions
   localparam int STAT_FLAG_BIT = 0;
   localparam int STAT_OVR_BIT  = 1;
   // control word bit positions
   localparam int CTRL_IE_BIT   = 0;

   typedef struct packed {
      logic ovr;
      logic flag;
   } cap_stat_t;
endpackage

// File: rtl/mtc_sync_edge.sv
module mtc_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise_evt
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("mtc_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sync_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], async_in};
         last_q <= sync_q[STAGES-1];
      end
   end

   assign rise_evt = sync_q[STAGES-1] & ~last_q;

   // one rising edge yields a single-cycle event
   assert_evt_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rise_evt |=> !rise_evt);
endmodule

// File: rtl/mtc_counter.sv
module mtc_counter #(
   parameter int CNT_W  = 64,
   parameter int DATA_W = 32,
   localparam int NWORD = CNT_W / DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NWORD-1:0]  wr_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [CNT_W-1:0]  cnt
);
   generate
      if (CNT_W % DATA_W != 0) begin : g_bad_split
         $error("mtc_counter: CNT_W must be a multiple of DATA_W");
      end
   endgenerate

   logic             wr_any;
   logic [CNT_W-1:0] cnt_inc;
   logic [CNT_W-1:0] cnt_nxt;

   assign wr_any  = |wr_en;
   assign cnt_inc = cnt + CNT_W'(1);

   genvar gi;
   generate
      for (gi = 0; gi < NWORD; gi++) begin : g_word
         always_comb begin
            if (wr_en[gi])
               cnt_nxt[gi*DATA_W +: DATA_W] = wdata;
            else if (wr_any)
               cnt_nxt[gi*DATA_W +: DATA_W] = cnt[gi*DATA_W +: DATA_W];
            else
               cnt_nxt[gi*DATA_W +: DATA_W] = cnt_inc[gi*DATA_W +: DATA_W];
         end

         assert_word_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en[gi] |=> cnt[gi*DATA_W +: DATA_W] == $past(wdata));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt_nxt;
   end

   assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_any |=> cnt == $past(cnt) + CNT_W'(1));
endmodule

// File: rtl/mtc_compare.sv
module mtc_compare #(
   parameter int CNT_W  = 64,
   parameter int DATA_W = 32,
   localparam int NWORD = CNT_W / DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NWORD-1:0]  wr_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic [CNT_W-1:0]  cnt,
   output logic [CNT_W-1:0]  cmp,
   output logic              hit
);
   genvar gi;
   generate
      for (gi = 0; gi < NWORD; gi++) begin : g_word
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         cmp[gi*DATA_W +: DATA_W] <= '1;
            else if (wr_en[gi]) cmp[gi*DATA_W +: DATA_W] <= wdata;
         end
      end
   endgenerate

   assign hit = (cnt >= cmp);

   assert_cmp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(|wr_en) |=> $stable(cmp));
endmodule

// File: rtl/mtc_capture.sv
module mtc_capture #(
   parameter int CNT_W = 64
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    evt,
   input  logic [CNT_W-1:0]        cnt,
   input  logic                    clr_flag,
   input  logic                    clr_ovr,
   output logic [CNT_W-1:0]        cap,
   output mtc_pkg::cap_stat_t      stat
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap  <= '0;
         stat <= '0;
      end else begin
         if (evt) cap <= cnt;
         stat.flag <= evt | (stat.flag & ~clr_flag);
         stat.ovr  <= (evt & stat.flag) | (stat.ovr & ~clr_ovr);
      end
   end

   assert_cap_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> cap == $past(cnt));
   assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> stat.flag);
   assert_overrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && stat.flag) |=> stat.ovr);
   assert_w1c_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_flag && !evt) |=> !stat.flag);
   assert_w0_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_ovr && stat.ovr) |=> stat.ovr);
endmodule

// File: rtl/mtc_timer_cap.sv
module mtc_timer_cap #(
   parameter int CNT_W       = 64,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_in,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   import mtc_pkg::*;

   localparam int NWORD     = CNT_W / DATA_W;
   localparam int CNT_BASE  = 0;
   localparam int CMP_BASE  = NWORD;
   localparam int CAP_BASE  = 2 * NWORD;
   localparam int STAT_ADDR = 3 * NWORD;
   localparam int CTRL_ADDR = 3 * NWORD + 1;

   generate
      if (DATA_W < 2) begin : g_bad_data
         $error("mtc_timer_cap: DATA_W must hold the status bits");
      end
      if ((1 << ADDR_W) < CTRL_ADDR + 1) begin : g_bad_addr
         $error("mtc_timer_cap: ADDR_W too small for the register map");
      end
   endgenerate

   logic [NWORD-1:0] cnt_wr, cmp_wr;
   logic [CNT_W-1:0] cnt, cmp, cap;
   logic             cmp_hit, cap_evt, cap_ie;
   logic             stat_wr, ctrl_wr;
   cap_stat_t        stat;

   genvar gi;
   generate
      for (gi = 0; gi < NWORD; gi++) begin : g_dec
         assign cnt_wr[gi] = bus_wr && (bus_addr == ADDR_W'(CNT_BASE + gi));
         assign cmp_wr[gi] = bus_wr && (bus_addr == ADDR_W'(CMP_BASE + gi));
      end
   endgenerate

   assign stat_wr = bus_wr && (bus_addr == ADDR_W'(STAT_ADDR));
   assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(CTRL_ADDR));

   mtc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(cap_in), .rise_evt(cap_evt));

   mtc_counter #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .wr_en(cnt_wr), .wdata(bus_wdata), .cnt(cnt));

   mtc_compare #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cmp (
      .clk(clk), .rst_n(rst_n), .wr_en(cmp_wr), .wdata(bus_wdata),
      .cnt(cnt), .cmp(cmp), .hit(cmp_hit));

   mtc_capture #(.CNT_W(CNT_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .evt(cap_evt), .cnt(cnt),
      .clr_flag(stat_wr && bus_wdata[STAT_FLAG_BIT]),
      .clr_ovr(stat_wr && bus_wdata[STAT_OVR_BIT]),
      .cap(cap), .stat(stat));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cap_ie <= 1'b0;
      else if (ctrl_wr) cap_ie <= bus_wdata[CTRL_IE_BIT];
   end

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NWORD; i++) begin
         if (bus_addr == ADDR_W'(CNT_BASE + i)) bus_rdata = cnt[i*DATA_W +: DATA_W];
         if (bus_addr == ADDR_W'(CMP_BASE + i)) bus_rdata = cmp[i*DATA_W +: DATA_W];
         if (bus_addr == ADDR_W'(CAP_BASE + i)) bus_rdata = cap[i*DATA_W +: DATA_W];
      end
      if (bus_addr == ADDR_W'(STAT_ADDR)) begin
         bus_rdata[STAT_FLAG_BIT] = stat.flag;
         bus_rdata[STAT_OVR_BIT]  = stat.ovr;
      end
      if (bus_addr == ADDR_W'(CTRL_ADDR)) bus_rdata[CTRL_IE_BIT] = cap_ie;
   end

   assign irq = (stat.flag & cap_ie) | cmp_hit;

   assert_ie_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> cap_ie == $past(bus_wdata[CTRL_IE_BIT]));
endmodule

// File: tb/mtc_timer_cap_bench.sv
module mtc_timer_cap_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cap_in = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   mtc_timer_cap u_mtc_timer_cap (
      .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

   // reference model built from the requirements
   logic [63:0] m_cnt, m_cmp, m_cap;
   logic        m_flag, m_ovr, m_ie, m_s1, m_s2, m_s3;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt <= '0; m_cmp <= '1; m_cap <= '0;
         m_flag <= 0; m_ovr <= 0; m_ie <= 0;
         m_s1 <= 0; m_s2 <= 0; m_s3 <= 0;
      end else begin : upd
         bit ev;
         ev = m_s2 & ~m_s3;
         m_s1 <= cap_in; m_s2 <= m_s1; m_s3 <= m_s2;
         if (bus_wr && bus_addr == 3'd0)      m_cnt <= {m_cnt[63:32], bus_wdata};
         else if (bus_wr && bus_addr == 3'd1) m_cnt <= {bus_wdata, m_cnt[31:0]};
         else                                 m_cnt <= m_cnt + 64'd1;
         if (bus_wr && bus_addr == 3'd2) m_cmp <= {m_cmp[63:32], bus_wdata};
         if (bus_wr && bus_addr == 3'd3) m_cmp <= {bus_wdata, m_cmp[31:0]};
         if (bus_wr && bus_addr == 3'd7) m_ie <= bus_wdata[0];
         if (ev) m_cap <= m_cnt;
         m_flag <= ev | (m_flag & ~(bus_wr && bus_addr == 3'd6 && bus_wdata[0]));
         m_ovr  <= (ev & m_flag) | (m_ovr & ~(bus_wr && bus_addr == 3'd6 && bus_wdata[1]));
      end
   end

   function automatic logic [31:0] exp_read(logic [2:0] a);
      case (a)
         3'd0: return m_cnt[31:0];
         3'd1: return m_cnt[63:32];
         3'd2: return m_cmp[31:0];
         3'd3: return m_cmp[63:32];
         3'd4: return m_cap[31:0];
         3'd5: return m_cap[63:32];
         3'd6: return {30'd0, m_ovr, m_flag};
         default: return {31'd0, m_ie};
      endcase
   endfunction

   function automatic string tag_of(logic [2:0] a);
      case (a)
         3'd0, 3'd1: return "R1";
         3'd2, 3'd3: return "R7";
         3'd4, 3'd5: return "R3";
         3'd6: return "R5";
         default: return "R10";
      endcase
   endfunction

   function automatic logic exp_irq();
      return (m_flag & m_ie) | (m_cnt >= m_cmp);
   endfunction

   task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [2:0] a, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 0;
   endtask

   task automatic rd_chk(logic [2:0] a, string tag);
      @(negedge clk);
      bus_wr = 0; bus_addr = a;
      #1;
      chk(bus_rdata == exp_read(a), tag, 64'(bus_rdata), 64'(exp_read(a)));
   endtask

   task automatic pulse(int hi);
      @(negedge clk); cap_in = 1;
      repeat (hi) @(negedge clk);
      cap_in = 0;
   endtask

   // R8: irq checked against the model every cycle once out of reset
   always @(negedge clk) begin
      if (rst_n && !done) begin
         #2;
         chk(irq == exp_irq(), "R8 irq", 64'(irq), 64'(exp_irq()));
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         bad++; total++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [63:0] tgt;
      void'($urandom(32'd4242));
      // R11: reset values while reset is held
      repeat (3) @(negedge clk);
      for (int a = 0; a < 8; a++) begin
         bus_addr = 3'(a); #1;
         chk(bus_rdata == ((a == 2 || a == 3) ? 32'hFFFF_FFFF : 32'h0), "R11 reset",
             64'(bus_rdata), (a == 2 || a == 3) ? 64'hFFFF_FFFF : 64'h0);
      end
      chk(irq == 1'b0, "R11 irq", 64'(irq), 64'h0);
      @(negedge clk); rst_n = 1;

      // R1: counting
      rd_chk(3'd0, "R1 count");
      repeat (5) @(negedge clk);
      rd_chk(3'd0, "R1 count later");
      rd_chk(3'd1, "R1 count hi");

      // R7: compare boundary
      tgt = m_cnt + 64'd40;
      wr(3'd3, tgt[63:32]);
      wr(3'd2, tgt[31:0]);
      for (int n = 0; n < 100; n++) begin
         @(negedge clk); #3;
         if (m_cnt == m_cmp - 64'd1) break;
      end
      chk(irq == 1'b0, "R7 below compare", 64'(irq), 64'h0);
      @(negedge clk); #3;
      chk(irq == 1'b1, "R7 at compare", 64'(irq), 64'h1);

      // R9: half writes and R1 wrap
      wr(3'd0, 32'hFFFF_FFFE);
      rd_chk(3'd0, "R9 low write");
      rd_chk(3'd1, "R9 high kept");
      wr(3'd1, 32'hFFFF_FFFF);
      wr(3'd0, 32'hFFFF_FFFD);
      rd_chk(3'd0, "R1 near wrap");
      repeat (4) @(negedge clk);
      rd_chk(3'd1, "R1 wrap high");
      rd_chk(3'd0, "R1 wrap low");
      wr(3'd3, 32'hFFFF_FFFF);
      wr(3'd2, 32'hFFFF_FFFF);

      // R2 R3 R4: first capture, enabled
      wr(3'd7, 32'h1);
      rd_chk(3'd7, "R10 control");
      pulse(3);
      repeat (4) @(negedge clk);
      rd_chk(3'd6, "R4 flag");
      #1 chk(bus_rdata == 32'h1, "R4 status value", 64'(bus_rdata), 64'h1);
      rd_chk(3'd4, "R3 capture lo");
      rd_chk(3'd5, "R3 capture hi");
      #1 chk(irq == 1'b1, "R8 capture irq", 64'(irq), 64'h1);
      // R5: second capture while flag set
      pulse(2);
      repeat (4) @(negedge clk);
      rd_chk(3'd6, "R5 overrun");
      #1 chk(bus_rdata == 32'h3, "R5 status value", 64'(bus_rdata), 64'h3);
      rd_chk(3'd4, "R3 overwrite lo");
      // R6: write-one-to-clear
      wr(3'd6, 32'h0);
      rd_chk(3'd6, "R6 zero write");
      #1 chk(bus_rdata == 32'h3, "R6 zero keeps", 64'(bus_rdata), 64'h3);
      wr(3'd6, 32'h1);
      rd_chk(3'd6, "R6 clear flag");
      #1 chk(bus_rdata == 32'h2, "R6 flag only", 64'(bus_rdata), 64'h2);
      wr(3'd6, 32'h2);
      rd_chk(3'd6, "R6 clear overrun");
      wr(3'd7, 32'h0);
      pulse(1);
      repeat (4) @(negedge clk);
      #1 chk(irq == 1'b0, "R8 disabled capture", 64'(irq), 64'h0);

      // constrained random mix
      for (int it = 0; it < 4000; it++) begin
         int op;
         logic [2:0] a;
         op = int'($urandom_range(0, 9));
         a = 3'($urandom_range(0, 7));
         if (op < 3) begin
            if (a == 3'd6) wr(a, 32'($urandom_range(0, 3)));
            else if (a == 3'd1 || a == 3'd3) wr(a, $urandom() >> $urandom_range(0, 31));
            else wr(a, $urandom());
         end else if (op < 7) begin
            rd_chk(a, tag_of(a));
         end else begin
            @(negedge clk); cap_in = ~cap_in;
         end
      end
      rd_chk(3'd4, "R3 final");
      rd_chk(3'd6, "R6 final");

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule